// File: doc/BRIEF.md
# Parameterised Fibonacci LFSR Pseudorandom Generator

This block produces a pseudorandom word and a pseudorandom serial bit from a shift register with XOR feedback. The register width and the set of tapped positions are parameters. By default the register is 32 bits wide, and the feedback is taken from positions 32, 22, 2 and 1, counted from 1 at the least significant bit. On every enabled cycle the register moves one place toward its MSB, and the XOR of the tapped bits fills the vacated LSB. The taps fix the order of the states, and the seed only picks where in that order the sequence starts.

A load strobe writes a caller-supplied seed into the register. An all-zero seed would lock the register at zero for good, so the block loads the value 1 in its place. Reset loads all ones. A 3-bit build with taps at positions 3 and 2 runs through a short, fully known cycle, which is used to check the block exhaustively.

Top module: `lfsr_prng`

## Requirements
- R1: After synchronous reset the register holds all ones (0x7 in the 3-bit build, 0xFFFFFFFF in the default build).
- R2: When `en`=1 and `load`=0 the next state is `{state[W-2:0], fb}`, where fb is the XOR of the bits whose position is set in `TAPS`. By default these are bit indices 31, 21, 1 and 0 (`TAPS`=0x80200003).
- R3: When `load`=1 and `seed` is nonzero, the register holds `seed` on the following cycle.
- R4: When `load`=1 and `seed` is all zeros, the register holds the value 1 (only bit 0 set) on the following cycle.
- R5: When `load` and `en` are both 1, the load takes effect and no shift happens.
- R6: When `en`=0 and `load`=0 the register keeps its value, whatever `seed` carries.
- R7: `serial_o` equals the MSB of the current state, which is the bit discarded by the next shift.
- R8: In the 3-bit build with `TAPS`=3'b110, starting from 7 the states are 7, 6, 4, 1, 2, 5, 3 and then 7 again. Every nonzero seed comes back to itself after exactly 7 shifts.
- R9: Once reset has been released, the register never holds zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the register by one step |
| load | input | 1 | Load strobe for `seed`; takes priority over `en` |
| seed | input | WIDTH | Start value written when `load` is 1 |
| state_o | output | WIDTH | Current register contents |
| serial_o | output | 1 | Serial pseudorandom bit (MSB of the register) |

## Verification
The condition that is hardest to reach from the ports is the zero state: a correct register never enters it by shifting, so it can only be approached by loading an all-zero seed. The bench does exactly that, in both the 3-bit build and the default build, and confirms the substitute value of 1. It also sets `en` together with `load` to show that the load wins. In the 3-bit build every nonzero seed is loaded and run for a full period, so every state and every transition is visited. The default build is run for thousands of steps, with `en` gated on and off, against an arithmetic model of the taps.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    // Action the register takes on the next clock edge
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SHIFT = 2'd1,
        ACT_LOAD  = 2'd2
    } lfsr_act_e;

    // Control word handed from the decoder to the register stage
    typedef struct packed {
        lfsr_act_e act;
        logic      seed_zero;
    } lfsr_ctrl_t;

    // Load beats enable; enable beats hold
    function automatic lfsr_act_e pick_action(input logic load, input logic en);
        if (load)
            return ACT_LOAD;
        else if (en)
            return ACT_SHIFT;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] seed,
    output logic             seed_zero
);
    // Flags the one seed value that would lock the register
    assign seed_zero = (seed == '0);
endmodule

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
    parameter int               WIDTH = 32,
    parameter logic [WIDTH-1:0] TAPS  = 32'h8020_0003
) (
    input  logic [WIDTH-1:0] state,
    output logic             fb
);
    logic [WIDTH-1:0] tapped;

    // One gate per position; positions not in the mask contribute zero
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        if (TAPS[i]) begin : g_on
            assign tapped[i] = state[i];
        end else begin : g_off
            assign tapped[i] = 1'b0;
        end
    end

    assign fb = ^tapped;
endmodule

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl
    import lfsr_pkg::*;
(
    input  logic       load,
    input  logic       en,
    input  logic       seed_zero,
    output lfsr_ctrl_t ctrl
);
    always_comb begin
        ctrl.act       = pick_action(load, en);
        ctrl.seed_zero = seed_zero;
    end
endmodule

// File: rtl/lfsr_prng.sv
module lfsr_prng
    import lfsr_pkg::*;
#(
    parameter int               WIDTH = 32,
    parameter logic [WIDTH-1:0] TAPS  = 32'h8020_0003
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] state_o,
    output logic             serial_o
);
    localparam logic [WIDTH-1:0] RESET_SEED = '1;
    localparam logic [WIDTH-1:0] ZERO_SUB   = {{(WIDTH-1){1'b0}}, 1'b1};

    if (WIDTH < 2) begin : g_bad_width
        $error("lfsr_prng: WIDTH must be at least 2");
    end
    if (!TAPS[WIDTH-1]) begin : g_bad_taps
        $error("lfsr_prng: the top position must be tapped");
    end

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;
    logic             fb;
    logic             seed_zero;
    lfsr_ctrl_t       ctrl;

    lfsr_seed_guard #(.WIDTH(WIDTH)) u_guard (
        .seed      (seed),
        .seed_zero (seed_zero)
    );

    lfsr_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
        .state (state_q),
        .fb    (fb)
    );

    lfsr_ctrl u_ctrl (
        .load      (load),
        .en        (en),
        .seed_zero (seed_zero),
        .ctrl      (ctrl)
    );

    always_comb begin
        unique case (ctrl.act)
            ACT_LOAD:  state_d = ctrl.seed_zero ? ZERO_SUB : seed;
            ACT_SHIFT: state_d = {state_q[WIDTH-2:0], fb};
            default:   state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= RESET_SEED;
        else
            state_q <= state_d;
    end

    assign state_o  = state_q;
    assign serial_o = state_q[WIDTH-1];
endmodule

// File: rtl/lfsr_prng_chk.sv
module lfsr_prng_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             load,
    input logic [WIDTH-1:0] seed,
    input logic [WIDTH-1:0] state_o
);
    localparam logic [WIDTH-1:0] SUB = {{(WIDTH-1){1'b0}}, 1'b1};

    a_r9_never_zero: assert property (@(posedge clk) disable iff (rst)
        state_o != '0);

    a_r3_load_seed: assert property (@(posedge clk) disable iff (rst)
        (load && seed != '0) |=> state_o == $past(seed));

    a_r4_zero_sub: assert property (@(posedge clk) disable iff (rst)
        (load && seed == '0) |=> state_o == SUB);

    a_r5_load_wins: assert property (@(posedge clk) disable iff (rst)
        (load && en && seed != '0) |=> state_o == $past(seed));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !en) |=> $stable(state_o));

    a_r2_shift_up: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> state_o[WIDTH-1:1] == $past(state_o[WIDTH-2:0]));
endmodule

bind lfsr_prng lfsr_prng_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .load    (load),
    .seed    (seed),
    .state_o (state_o)
);

// File: tb/test_lfsr_prng.sv
module test_lfsr_prng;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;

    // default 32-bit build
    logic        en_b = 1'b0, load_b = 1'b0;
    logic [31:0] seed_b = '0;
    logic [31:0] state_b;
    logic        serial_b;

    // 3-bit build
    logic        en_s = 1'b0, load_s = 1'b0;
    logic [2:0]  seed_s = '0;
    logic [2:0]  state_s;
    logic        serial_s;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lfsr_prng i_lfsr_prng (
        .clk(clk), .rst(rst), .en(en_b), .load(load_b), .seed(seed_b),
        .state_o(state_b), .serial_o(serial_b)
    );

    lfsr_prng #(.WIDTH(3), .TAPS(3'b110)) i_lfsr_prng_small (
        .clk(clk), .rst(rst), .en(en_s), .load(load_s), .seed(seed_s),
        .state_o(state_s), .serial_o(serial_s)
    );

    function automatic logic [31:0] next_big(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [2:0] next_small(input logic [2:0] s);
        return {s[1:0], s[2] ^ s[1]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // drive at negedge, sample just after the next posedge
    task automatic tick_small(input logic en, input logic ld, input logic [2:0] sd);
        @(negedge clk);
        en_s = en; load_s = ld; seed_s = sd;
        @(posedge clk);
        #1;
    endtask

    task automatic tick_big(input logic en, input logic ld, input logic [31:0] sd);
        @(negedge clk);
        en_b = en; load_b = ld; seed_b = sd;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [2:0]  exp_s;
        logic [31:0] exp_b;
        logic [2:0]  ring [7];
        ring = '{3'd6, 3'd4, 3'd1, 3'd2, 3'd5, 3'd3, 3'd7};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 small reset", {29'd0, state_s}, 32'd7);
        check("R1 big reset", state_b, 32'hFFFF_FFFF);
        // R7 serial is MSB
        check("R7 big serial after reset", {31'd0, serial_b}, 32'd1);

        // R8 known ring from 7
        tick_small(1'b0, 1'b1, 3'd7);
        check("R3 small load 7", {29'd0, state_s}, 32'd7);
        for (int k = 0; k < 7; k++) begin
            tick_small(1'b1, 1'b0, 3'd0);
            check("R8 ring order", {29'd0, state_s}, {29'd0, ring[k]});
        end

        // R2 R7 R8 R9: sweep every nonzero seed over a full period
        for (int sd = 1; sd < 8; sd++) begin
            tick_small(1'b0, 1'b1, sd[2:0]);
            check("R3 small seed", {29'd0, state_s}, sd);
            exp_s = sd[2:0];
            for (int k = 0; k < 7; k++) begin
                check("R7 small serial", {31'd0, serial_s}, {31'd0, exp_s[2]});
                tick_small(1'b1, 1'b0, 3'd0);
                exp_s = next_small(exp_s);
                check("R2 small step", {29'd0, state_s}, {29'd0, exp_s});
                check("R9 small nonzero", {31'd0, state_s != 3'd0}, 32'd1);
            end
            check("R8 period 7", {29'd0, state_s}, sd);
        end

        // R4 zero seed substitution
        tick_small(1'b0, 1'b1, 3'd0);
        check("R4 small zero seed", {29'd0, state_s}, 32'd1);
        tick_big(1'b0, 1'b1, 32'd0);
        check("R4 big zero seed", state_b, 32'd1);
        // zero seed with enable also set
        tick_small(1'b1, 1'b1, 3'd0);
        check("R4 R5 small zero seed with en", {29'd0, state_s}, 32'd1);

        // R5 load wins over enable
        tick_small(1'b1, 1'b1, 3'd5);
        check("R5 small load priority", {29'd0, state_s}, 32'd5);
        tick_big(1'b1, 1'b1, 32'hDEAD_BEEF);
        check("R5 big load priority", state_b, 32'hDEAD_BEEF);

        // R6 hold with seed changing
        for (int k = 0; k < 4; k++) begin
            tick_small(1'b0, 1'b0, k[2:0]);
            check("R6 small hold", {29'd0, state_s}, 32'd5);
            tick_big(1'b0, 1'b0, 32'h0 + k);
            check("R6 big hold", state_b, 32'hDEAD_BEEF);
        end

        // R2 R7 R9 long run of default build with gated enable
        tick_big(1'b0, 1'b1, 32'h1234_5678);
        check("R3 big load", state_b, 32'h1234_5678);
        exp_b = 32'h1234_5678;
        for (int k = 0; k < 3000; k++) begin
            logic e;
            e = (k % 5) != 0;
            check("R7 big serial", {31'd0, serial_b}, {31'd0, exp_b[31]});
            tick_big(e, 1'b0, 32'h0);
            if (e) exp_b = next_big(exp_b);
            check("R2 big step", state_b, exp_b);
            if (state_b == 32'd0)
                check("R9 big nonzero", state_b, 32'd1);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule